// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that gives a bus controller byte access to an external 8-bit register file. It oversamples SCL and SDA on the system clock through two-flop synchronisers and finds START, repeated START and STOP from edges on the synchronised lines. It decodes the address byte and the direction bit, and pulls SDA low through an open-drain enable to acknowledge bytes or to send read data. The 7-bit target address is fixed except for its two low bits. One comes from a strap pin captured just after reset. The other shows which of two bus pairs the target sits on.

In a write, the first byte after the address loads a byte-wide register pointer. Each later byte goes out on the register write port at the pointer, and the pointer then advances, wrapping from 0xFF to 0x00. A read sends bytes from the current pointer upward, taken from the combinational read port. The pointer keeps its value between transactions, so a read may start without a pointer phase. A write of 0xFF to a chosen command register sets a low-power idle flag. The flag has no effect on the bus. Any transaction that matches the target address clears the flag and emits a one-cycle wake pulse.

Top module: `i2c_strap_target`

## Requirements
- R1: The target acknowledges (SDA low during the ninth clock) an address byte whose upper seven bits equal {1,0,1,0,0,bus_sel_i,strap}; the low bit of the address byte is the direction, 0 = write and 1 = read.
- R2: For any other address the target leaves SDA released on the ninth clock and on every following clock until the next START, and it makes no register write.
- R3: In a write, the byte after the address sets the pointer, and each further byte appears on the write port at pointer K, K+1, ... in order, each acknowledged.
- R4: Pointer auto-increment wraps from 0xFF to 0x00, for writes and for reads.
- R5: After a pointer write and a repeated START with the read bit, the target sends the register bytes from K upward, MSB first, one per controller ACK.
- R6: A read with no pointer phase starts at the current pointer, which is 0x00 after reset and otherwise one past the last byte written or sent.
- R7: After the controller NACKs a read byte, the target keeps SDA released until the next START.
- R8: The strap pin is captured in the first cycle after reset ends; later changes do not alter the address.
- R9: A register write of 0xFF to the command register (CMD_ADDR, default 0x23) sets idle_o; a write of another value there does not set it.
- R10: Each transaction that matches the address clears idle_o and drives wake_o high for exactly one cycle; a non-matching transaction changes neither.
- R11: In reset and after it, sda_oe is 0, idle_o is 0, wake_o is 0 and the pointer is 0x00.
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| strap_i | input | 1 | Address strap, captured after reset |
| bus_sel_i | input | 1 | 0 = first bus pair, 1 = second bus pair |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_addr | output | 8 | Register read address (current pointer) |
| rd_data | input | 8 | Register read data for rd_addr |
| idle_o | output | 1 | Low-power idle flag |
| wake_o | output | 1 | One-cycle pulse on each matching address |

## Verification
A wrong pointer is the most likely internal fault. It shows up as wrong bytes at the register ports: as a misplaced write on the wr_addr strobe, or, when the read data is shifted out, as a wrong value within nine SCL periods. A state machine stuck in the wrong phase shows up as a missing or extra acknowledge on the ninth clock of the byte in progress, or as SDA held low after a NACK. A fault in the idle flag or the address latch shows up one system clock after the address byte or the command write, on idle_o and wake_o.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        tgt_state_e        state;
        rx_phase_e         phase;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shreg;
        logic              rnw;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic              hit;
        logic              ctl_nack;
    } fsm_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_d, pipe_q;
        logic              prev_d, prev_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], raw_i[g]};
            prev_d = pipe_q[LAST];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '1;
                prev_q <= 1'b1;
            end else begin
                pipe_q <= pipe_d;
                prev_q <= prev_d;
            end
        end

        assign level_o[g] = pipe_q[LAST];
        assign rise_o[g]  = pipe_q[LAST] & ~prev_q;
        assign fall_o[g]  = ~pipe_q[LAST] & prev_q;
    end

endmodule

// File: rtl/i2c_addr_select.sv
module i2c_addr_select #(
    parameter logic [4:0] ADDR_PREFIX = 5'b10100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_i,
    input  logic       bus_sel_i,
    output logic [6:0] my_addr_o
);

    typedef struct packed {
        logic taken;
        logic strap;
    } strap_regs_t;

    strap_regs_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b1;
        if (!st_q.taken) begin
            st_d.strap = strap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Before the capture edge the live pin is used, so the address is settled
    // from the first cycle on.
    assign my_addr_o = {ADDR_PREFIX, bus_sel_i, st_q.taken ? st_q.strap : strap_i};

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [6:0]        my_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              hit
);

    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);
    localparam logic [3:0] LAST_BIT      = 4'(BYTE_W - 1);

    fsm_regs_t r_d, r_q;

    logic bus_start, bus_stop;
    assign bus_start = sda_fall & scl_lvl;
    assign bus_stop  = sda_rise & scl_lvl;

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.hit   = 1'b0;

        if (bus_start) begin
            r_d.state = ST_RX;
            r_d.phase = PH_ADDR;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else if (bus_stop) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_RX: begin
                    if (scl_rise && r_q.cnt < BITS_PER_BYTE) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_lvl};
                        r_d.cnt   = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == BITS_PER_BYTE) begin
                        unique case (r_q.phase)
                            PH_ADDR: begin
                                if (r_q.shreg[BYTE_W-1:1] == my_addr) begin
                                    r_d.hit   = 1'b1;
                                    r_d.rnw   = r_q.shreg[0];
                                    r_d.oe    = 1'b1;
                                    r_d.state = ST_ACK;
                                end else begin
                                    r_d.oe    = 1'b0;
                                    r_d.state = ST_SKIP;
                                end
                            end
                            PH_PTR: begin
                                r_d.ptr   = r_q.shreg;
                                r_d.oe    = 1'b1;
                                r_d.state = ST_ACK;
                            end
                            default: begin
                                r_d.wr_en   = 1'b1;
                                r_d.wr_addr = r_q.ptr;
                                r_d.wr_data = r_q.shreg;
                                r_d.ptr     = r_q.ptr + 1'b1;
                                r_d.oe      = 1'b1;
                                r_d.state   = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.phase == PH_ADDR && r_q.rnw) begin
                            r_d.shreg = rd_data;
                            r_d.ptr   = r_q.ptr + 1'b1;
                            r_d.oe    = ~rd_data[BYTE_W-1];
                            r_d.state = ST_TX;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_RX;
                            r_d.phase = (r_q.phase == PH_ADDR) ? PH_PTR : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_RACK;
                        end else begin
                            r_d.shreg = {r_q.shreg[BYTE_W-2:0], 1'b0};
                            r_d.oe    = ~r_q.shreg[BYTE_W-2];
                            r_d.cnt   = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.ctl_nack = sda_lvl;
                    end else if (scl_fall) begin
                        r_d.cnt = '0;
                        if (!r_q.ctl_nack) begin
                            r_d.shreg = rd_data;
                            r_d.ptr   = r_q.ptr + 1'b1;
                            r_d.oe    = ~rd_data[BYTE_W-1];
                            r_d.state = ST_TX;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_SKIP;
                        end
                    end
                end
                default: begin
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.phase <= PH_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr = r_q.ptr;
    assign sda_oe  = r_q.oe;
    assign wr_en   = r_q.wr_en;
    assign wr_addr = r_q.wr_addr;
    assign wr_data = r_q.wr_data;
    assign hit     = r_q.hit;

endmodule

// File: rtl/i2c_idle_ctl.sv
module i2c_idle_ctl #(
    parameter int              AW        = 8,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   CMD_ADDR  = 8'h23,
    parameter logic [DW-1:0]   IDLE_CODE = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          hit,
    output logic          idle_o
);

    logic idle_d, idle_q;

    always_comb begin
        idle_d = idle_q;
        if (wr_en && wr_addr == CMD_ADDR && wr_data == IDLE_CODE) begin
            idle_d = 1'b1;
        end else if (hit) begin
            idle_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else begin
            idle_q <= idle_d;
        end
    end

    assign idle_o = idle_q;

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
    import i2c_tgt_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [4:0]      ADDR_PREFIX = 5'b10100,
    parameter logic [7:0]      CMD_ADDR    = 8'h23,
    parameter logic [7:0]      IDLE_CODE   = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       strap_i,
    input  logic       bus_sel_i,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic [7:0] rd_addr,
    input  logic [7:0] rd_data,
    output logic       idle_o,
    output logic       wake_o
);

    localparam int N_LINES = 2;
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    logic [N_LINES-1:0] lvl, rise, fall;
    logic [6:0]         my_addr;
    logic               hit;

    i2c_line_sync #(
        .LINES  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({sda_i, scl_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    i2c_addr_select #(
        .ADDR_PREFIX (ADDR_PREFIX)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap_i),
        .bus_sel_i (bus_sel_i),
        .my_addr_o (my_addr)
    );

    i2c_proto_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (lvl[SCL_IDX]),
        .scl_rise (rise[SCL_IDX]),
        .scl_fall (fall[SCL_IDX]),
        .sda_lvl  (lvl[SDA_IDX]),
        .sda_rise (rise[SDA_IDX]),
        .sda_fall (fall[SDA_IDX]),
        .my_addr  (my_addr),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hit      (hit)
    );

    i2c_idle_ctl #(
        .AW        (BYTE_W),
        .DW        (BYTE_W),
        .CMD_ADDR  (CMD_ADDR),
        .IDLE_CODE (IDLE_CODE)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit),
        .idle_o  (idle_o)
    );

    assign wake_o = hit;

endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
    parameter logic [7:0] CMD_ADDR  = 8'h23,
    parameter logic [7:0] IDLE_CODE = 8'hFF
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       idle_o,
    input logic       wake_o
);

    // R12: the data line drive never moves while the clock line is high
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R3: every written byte is acknowledged
    a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

    // R9: idle code to the command register sets the idle flag
    a_r9_idle_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CMD_ADDR && wr_data == IDLE_CODE) |=> idle_o);

    // R10: the wake pulse lasts one cycle
    a_r10_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R10: a matching address leaves the idle flag cleared
    a_r10_wake_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !idle_o);

    // R10: a wake never coincides with a register write
    a_r10_wake_not_write: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !wr_en);

endmodule

bind i2c_strap_target i2c_strap_target_chk #(
    .CMD_ADDR  (CMD_ADDR),
    .IDLE_CODE (IDLE_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .idle_o  (idle_o),
    .wake_o  (wake_o)
);

// File: tb/tb_i2c_strap_target.sv
module tb_i2c_strap_target;

    localparam int         CLK_P = 10;
    localparam int         Q     = 8;
    localparam logic [7:0] CMD   = 8'h23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       strap = 1'b1;
    logic       bus_sel = 1'b0;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic       idle_o, wake_o;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr;
    logic [7:0] wbuf    [4];
    logic [7:0] rbuf    [4];
    int         wr_count = 0;
    int         wake_count = 0;
    int         checks = 0;
    int         failures = 0;
    bit         finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    i2c_strap_target #(.CMD_ADDR(CMD)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_i   (strap),
        .bus_sel_i (bus_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .idle_o    (idle_o),
        .wake_o    (wake_o)
    );

    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_count     <= wr_count + 1;
        end
        if (rst_n && wake_o) wake_count <= wake_count + 1;
    end

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [6:0] tgt_addr(input logic s, input logic b);
        return {5'b10100, b, s};
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q(); wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        acked = (sda_line == 1'b0);
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl_m = 1'b1; wait_q();
            b[i] = sda_line;
            wait_q();
            scl_m = 1'b0;
        end
        wait_q();
        sda_m = mack ? 1'b0 : 1'b1; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] k, input int n,
                            output bit all_ack);
        bit ak;
        all_ack = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, ak); all_ack &= ak;
        send_byte(k, ak);         all_ack &= ak;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ak); all_ack &= ak;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input bit set_ptr, input logic [7:0] k,
                           input int n, output bit all_ack);
        bit ak;
        all_ack = 1'b1;
        bus_start();
        if (set_ptr) begin
            send_byte({a, 1'b0}, ak); all_ack &= ak;
            send_byte(k, ak);         all_ack &= ak;
            bus_start();
        end
        send_byte({a, 1'b1}, ak); all_ack &= ak;
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, rbuf[i]);
        end
        bus_stop();
    endtask

    task automatic model_write(input logic [7:0] k, input int n);
        for (int i = 0; i < n; i++) exp_mem[8'(k + i)] = wbuf[i];
        exp_ptr = 8'(k + n);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = pattern(i);
            exp_mem[i] = pattern(i);
        end
    end

    initial begin
        bit ok;
        int wc, kc;
        logic [6:0] me;
        void'($urandom(32'd1357));
        repeat (5) @(negedge clk);
        // R11: reset state
        check("R11 sda_oe in reset", sda_oe, 0);
        check("R11 idle in reset", idle_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        strap = 1'b0; // R8: late strap change must be ignored
        me = tgt_addr(1'b1, 1'b0);
        exp_ptr = 8'h00;
        check("R11 wake after reset", wake_o, 0);

        // R6 R11: read without pointer starts at 0x00 after reset
        do_read(me, 1'b0, 8'h00, 2, ok);
        check("R1 ack on address 0x51", ok, 1);
        check("R6 first byte from pointer 0", rbuf[0], exp_mem[0]);
        check("R6 second byte", rbuf[1], exp_mem[1]);
        exp_ptr = 8'h02;

        // R8 R2: address with live strap value is not ours
        wc = wr_count; kc = wake_count;
        wbuf[0] = 8'h5A;
        do_write(tgt_addr(1'b0, 1'b0), 8'h40, 1, ok);
        check("R8 strap change ignored, 0x50 not acked", ok, 0);
        check("R2 no write on mismatch", wr_count, wc);
        check("R10 no wake on mismatch", wake_count, kc);

        // R1: bus pair select moves the address
        bus_sel = 1'b1;
        do_write(tgt_addr(1'b1, 1'b0), 8'h40, 1, ok);
        check("R1 old address rejected on pair 2", ok, 0);
        wbuf[0] = 8'hC3;
        do_write(tgt_addr(1'b1, 1'b1), 8'h40, 1, ok);
        check("R1 address 0x53 acked on pair 2", ok, 1);
        model_write(8'h40, 1);
        check("R3 write on pair 2", mem[8'h40], 8'hC3);
        bus_sel = 1'b0;

        // R3: multi-byte write with auto-increment
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wc = wr_count;
        do_write(me, 8'h10, 3, ok);
        model_write(8'h10, 3);
        check("R3 all bytes acked", ok, 1);
        check("R3 write count", wr_count - wc, 3);
        check("R3 byte K", mem[8'h10], 8'h11);
        check("R3 byte K+2", mem[8'h12], 8'h33);

        // R6: read continues from pointer left by the write
        do_read(me, 1'b0, 8'h00, 1, ok);
        check("R6 read at persisted pointer", rbuf[0], exp_mem[8'h13]);
        exp_ptr = 8'h14;

        // R4: wrap on write and on read
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
        do_write(me, 8'hFE, 3, ok);
        model_write(8'hFE, 3);
        check("R4 write wraps to 0x00", mem[8'h00], 8'hA3);
        do_read(me, 1'b1, 8'hFF, 2, ok);
        check("R4 read at 0xFF", rbuf[0], 8'hA2);
        check("R4 read wraps to 0x00", rbuf[1], 8'hA3);
        exp_ptr = 8'h01;

        // R7: after NACK the target stays released
        do_read(me, 1'b1, 8'h00, 1, ok);
        begin
            int lows = 0;
            bus_start();
            send_byte({me, 1'b1}, ok);
            read_byte(1'b0, rbuf[0]);
            for (int i = 0; i < 9; i++) begin
                wait_q(); scl_m = 1'b1; wait_q();
                if (sda_line == 1'b0) lows++;
                wait_q(); scl_m = 1'b0; wait_q();
            end
            bus_stop();
            check("R7 SDA released after NACK", lows, 0);
            check("R7 byte before NACK", rbuf[0], exp_mem[8'h01]);
            exp_ptr = 8'h02;
        end

        // R5 R3 R6: random traffic
        for (int it = 0; it < 14; it++) begin
            logic [7:0] k;
            int n;
            k = 8'($urandom_range(0, 255));
            if (k == CMD) k = 8'h24;
            n = int'($urandom_range(1, 4));
            if ($urandom_range(0, 1) == 0) begin
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                do_write(me, k, n, ok);
                model_write(k, n);
                check("R3 random write acked", ok, 1);
                do_read(me, 1'b1, k, n, ok);
                for (int i = 0; i < n; i++)
                    check("R5 random readback", rbuf[i], exp_mem[8'(k + i)]);
                exp_ptr = 8'(k + n);
            end else begin
                do_read(me, 1'b0, 8'h00, n, ok);
                for (int i = 0; i < n; i++)
                    check("R6 random read at pointer", rbuf[i], exp_mem[8'(exp_ptr + i)]);
                exp_ptr = 8'(exp_ptr + n);
            end
        end

        // R9 R10: idle flag
        wbuf[0] = 8'h12;
        do_write(me, CMD, 1, ok);
        repeat (2) @(negedge clk);
        check("R9 other value leaves idle clear", idle_o, 0);
        wbuf[0] = 8'hFF;
        do_write(me, CMD, 1, ok);
        repeat (2) @(negedge clk);
        check("R9 idle set by 0xFF", idle_o, 1);
        kc = wake_count;
        do_write(tgt_addr(1'b0, 1'b1), 8'h00, 0, ok);
        check("R10 idle kept on mismatch", idle_o, 1);
        check("R10 no wake on mismatch", wake_count, kc);
        do_read(me, 1'b0, 8'h00, 1, ok);
        check("R10 idle cleared by access", idle_o, 0);
        check("R10 one wake per access", wake_count - kc, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule